// File: doc/BRIEF.md
# I2C Bus Status and Arbitration Monitor

This block sits next to an I2C controller. It watches the SCL and SDA lines and a few control signals from the controller, and it keeps an 8-bit status word for the host. From the lines it detects START and STOP conditions and tracks whether the bus is busy. It counts the bits of each byte, marks when a byte completes, compares the calling address with the block's own address, and records the direction bit and the acknowledge bit.

The controller reports whether it is a master, whether it is transmitting, whether it is releasing SDA (driving a one), and when it requests a start, a repeated start or a stop. The monitor uses these to spot five kinds of lost arbitration. Any completed byte, address match or arbitration loss sets a sticky interrupt flag. The host clears the two event flags by writing ones to them, and any write to the controller's control register clears the address-match flag. The block does not drive the serial clock and does not shift data out.

Top module: `i2c_stat_mon`

## Requirements
- R1: After reset every status bit reads 0 and the irq output is 0. Bit 3 of the status word always reads 0.
- R2: Bit 7 (transfer done) goes to 0 on the first SCL rise of a byte and goes to 1 on the SCL fall that ends the 9th clock of that byte.
- R3: Bit 6 (addressed) goes to 1 at the end of the first byte after a START when the controller is not a master and bits 7..1 of that byte equal own_addr. A ctrl_wr pulse clears it.
- R4: Bit 5 (busy) goes to 1 when SDA falls while SCL is high (START). It goes to 0 when SDA rises while SCL is high (STOP).
- R5: Bit 2 takes bit 0 (the read/write bit) of an address byte that matched. Bit 0 takes the SDA level at the 9th SCL rise of every byte, so 0 means the byte was acknowledged.
- R6: Bit 4 (arbitration lost) goes to 1 when, as a master, in an address bit or a transmitted data bit, sda_drive_hi is 1 and SDA is sampled 0 at the SCL rise.
- R7: Bit 4 goes to 1 when, as a master receiving a data byte, sda_drive_hi is 1 during the acknowledge bit and SDA is sampled 0. Bits received before the acknowledge do not set it.
- R8: Bit 4 goes to 1 on a start_req pulse while the bus is busy, and on an rstart_req pulse while master_mode is 0. A start_req while idle, or an rstart_req as master, leaves it at 0.
- R9: Bit 4 goes to 1 when a STOP is seen while master_mode is 1 and stop_req is 0. With stop_req at 1 the STOP does not set it.
- R10: A stat_wr with data bit 4 at 1 clears bit 4, and with data bit 1 at 1 clears bit 1. A data bit at 0 leaves these bits unchanged, and writes have no effect on any other bit.
- R11: Bit 1 (interrupt flag) goes to 1 on a byte completion, an address match or an arbitration loss. The irq output equals bit 1 AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| own_addr | input | ADDR_W | Slave address of this device |
| master_mode | input | 1 | Controller is a bus master |
| tx_mode | input | 1 | Controller transmits the current data byte |
| sda_drive_hi | input | 1 | Controller releases SDA to send a one |
| start_req | input | 1 | Pulse: controller asks for a START |
| rstart_req | input | 1 | Pulse: controller asks for a repeated START |
| stop_req | input | 1 | Controller has requested the STOP on the bus |
| ctrl_wr | input | 1 | Pulse: host wrote the control register |
| stat_wr | input | 1 | Pulse: host writes the status word |
| stat_wdata | input | 8 | Status write data (ones clear bits 4 and 1) |
| irq_en | input | 1 | Interrupt enable |
| stat_rdata | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
A change on SCL or SDA reaches the status word at the third rising clock edge after it is applied: two synchronizer flops, then the status register. A host write, a ctrl_wr pulse or a request pulse shows in the status word one edge later, and irq follows bit 1 in the same cycle. The bench holds every SCL phase for four clocks and samples on the falling edge at the end of a phase or two clocks after a pulse, so each result is already settled and the next stimulus has not yet arrived.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int STAT_W    = 8;
   localparam int BYTE_BITS = 8;
   localparam int ACK_SLOT  = BYTE_BITS;        // index of the 9th clock
   localparam int CNT_W     = $clog2(BYTE_BITS + 2);

   // status word bit positions
   localparam int B_XFER_DONE = 7;
   localparam int B_ADDR_HIT  = 6;
   localparam int B_BUSY      = 5;
   localparam int B_ARB_LOST  = 4;
   localparam int B_RSVD      = 3;
   localparam int B_SLV_RW    = 2;
   localparam int B_IRQ_FLAG  = 1;
   localparam int B_ACK_IN    = 0;

   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } line_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
   import i2c_stat_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     line_in,
   output line_ev_t ev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= line_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];
   end

   always_comb begin
      ev.level = chain[STAGES-1];
      ev.rise  = chain[STAGES-1] & ~prev;
      ev.fall  = ~chain[STAGES-1] & prev;
   end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
   import i2c_stat_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  line_ev_t scl,
   input  line_ev_t sda,
   output logic     start_det,
   output logic     stop_det,
   output logic     busy
);
   assign start_det = sda.fall & scl.level & ~scl.rise;
   assign stop_det  = sda.rise & scl.level & ~scl.rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end
endmodule

// File: rtl/i2c_bit_track.sv
module i2c_bit_track
   import i2c_stat_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          scl,
   input  line_ev_t          sda,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              busy,
   input  logic              master_mode,
   input  logic [ADDR_W-1:0] own_addr,
   output logic [CNT_W-1:0]  bit_idx,
   output logic              addr_phase,
   output logic              byte_begin,
   output logic              byte_done,
   output logic              addr_hit,
   output logic              slv_rw,
   output logic              ack_in
);
   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_BITS - 1) begin : g_bad_addr
         $error("i2c_bit_track: ADDR_W must be 1..7");
      end
   endgenerate

   logic [BYTE_BITS-1:0] shreg;
   logic                 last_fall;

   assign byte_begin = busy & scl.rise & (bit_idx == '0);
   assign last_fall  = busy & scl.fall & (bit_idx == CNT_W'(ACK_SLOT + 1));
   assign byte_done  = last_fall & ~start_det & ~stop_det;
   assign addr_hit   = byte_done & addr_phase & ~master_mode &
                       (shreg[BYTE_BITS-1 -: ADDR_W] == own_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx    <= '0;
         addr_phase <= 1'b0;
         shreg      <= '0;
      end else if (start_det) begin
         bit_idx    <= '0;
         addr_phase <= 1'b1;
      end else if (stop_det) begin
         bit_idx    <= '0;
         addr_phase <= 1'b0;
      end else if (busy) begin
         if (scl.rise && bit_idx <= CNT_W'(ACK_SLOT)) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx < CNT_W'(BYTE_BITS))
               shreg <= {shreg[BYTE_BITS-2:0], sda.level};
         end else if (last_fall) begin
            bit_idx    <= '0;
            addr_phase <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slv_rw <= 1'b0;
         ack_in <= 1'b0;
      end else begin
         if (busy && scl.rise && bit_idx == CNT_W'(ACK_SLOT))
            ack_in <= sda.level;
         if (addr_hit)
            slv_rw <= shreg[0];
      end
   end
endmodule

// File: rtl/i2c_arb_detect.sv
module i2c_arb_detect
   import i2c_stat_pkg::*;
(
   input  line_ev_t         scl,
   input  line_ev_t         sda,
   input  logic             busy,
   input  logic             stop_det,
   input  logic [CNT_W-1:0] bit_idx,
   input  logic             addr_phase,
   input  logic             master_mode,
   input  logic             tx_mode,
   input  logic             sda_drive_hi,
   input  logic             start_req,
   input  logic             rstart_req,
   input  logic             stop_req,
   output logic             arb_hit
);
   logic mismatch, tx_bit, rx_ack, busy_start, slave_rstart, stray_stop;

   assign mismatch     = busy & scl.rise & master_mode & sda_drive_hi & ~sda.level;
   assign tx_bit       = mismatch & (addr_phase | tx_mode) & (bit_idx < CNT_W'(BYTE_BITS));
   assign rx_ack       = mismatch & ~addr_phase & ~tx_mode & (bit_idx == CNT_W'(ACK_SLOT));
   assign busy_start   = start_req & busy;
   assign slave_rstart = rstart_req & ~master_mode;
   assign stray_stop   = stop_det & master_mode & ~stop_req;

   assign arb_hit = tx_bit | rx_ack | busy_start | slave_rstart | stray_stop;
endmodule

// File: rtl/i2c_stat_mon.sv
module i2c_stat_mon
   import i2c_stat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 7,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              master_mode,
   input  logic              tx_mode,
   input  logic              sda_drive_hi,
   input  logic              start_req,
   input  logic              rstart_req,
   input  logic              stop_req,
   input  logic              ctrl_wr,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   input  logic              irq_en,
   output logic [STAT_W-1:0] stat_rdata,
   output logic              irq
);
   line_ev_t         scl_ev, sda_ev;
   logic             start_det, stop_det, busy;
   logic [CNT_W-1:0] bit_idx;
   logic             addr_phase, byte_begin, byte_done, addr_hit;
   logic             slv_rw, ack_in, arb_set;
   logic             xfer_done_q, addr_hit_q, arb_lost_q, irq_flag_q;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_in(scl_in), .ev(scl_ev));
   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_in(sda_in), .ev(sda_ev));

   i2c_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl(scl_ev), .sda(sda_ev),
      .start_det(start_det), .stop_det(stop_det), .busy(busy));

   i2c_bit_track #(.ADDR_W(ADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .scl(scl_ev), .sda(sda_ev),
      .start_det(start_det), .stop_det(stop_det), .busy(busy),
      .master_mode(master_mode), .own_addr(own_addr),
      .bit_idx(bit_idx), .addr_phase(addr_phase), .byte_begin(byte_begin),
      .byte_done(byte_done), .addr_hit(addr_hit),
      .slv_rw(slv_rw), .ack_in(ack_in));

   i2c_arb_detect u_arb (
      .scl(scl_ev), .sda(sda_ev), .busy(busy), .stop_det(stop_det),
      .bit_idx(bit_idx), .addr_phase(addr_phase),
      .master_mode(master_mode), .tx_mode(tx_mode), .sda_drive_hi(sda_drive_hi),
      .start_req(start_req), .rstart_req(rstart_req), .stop_req(stop_req),
      .arb_hit(arb_set));

   // event flags: a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_done_q <= 1'b0;
         addr_hit_q  <= 1'b0;
         arb_lost_q  <= 1'b0;
         irq_flag_q  <= 1'b0;
      end else begin
         if (byte_done)       xfer_done_q <= 1'b1;
         else if (byte_begin) xfer_done_q <= 1'b0;

         if (addr_hit)     addr_hit_q <= 1'b1;
         else if (ctrl_wr) addr_hit_q <= 1'b0;

         if (arb_set)                             arb_lost_q <= 1'b1;
         else if (stat_wr && stat_wdata[B_ARB_LOST]) arb_lost_q <= 1'b0;

         if (byte_done || addr_hit || arb_set)    irq_flag_q <= 1'b1;
         else if (stat_wr && stat_wdata[B_IRQ_FLAG]) irq_flag_q <= 1'b0;
      end
   end

   always_comb begin
      stat_rdata              = '0;
      stat_rdata[B_XFER_DONE] = xfer_done_q;
      stat_rdata[B_ADDR_HIT]  = addr_hit_q;
      stat_rdata[B_BUSY]      = busy;
      stat_rdata[B_ARB_LOST]  = arb_lost_q;
      stat_rdata[B_SLV_RW]    = slv_rw;
      stat_rdata[B_IRQ_FLAG]  = irq_flag_q;
      stat_rdata[B_ACK_IN]    = ack_in;
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_flag_q & irq_en;
         end
      end else begin : g_irq_comb
         assign irq = irq_flag_q & irq_en;
      end
   endgenerate
endmodule

// File: rtl/i2c_stat_mon_chk.sv
module i2c_stat_mon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] stat_rdata,
   input logic       stat_wr,
   input logic [7:0] stat_wdata,
   input logic       ctrl_wr,
   input logic       arb_set,
   input logic       addr_hit,
   input logic       byte_done,
   input logic       start_det,
   input logic       stop_det
);
   always @(posedge clk)
      if (rst_n) a_r1_rsvd_zero : assert (!stat_rdata[3]);

   a_r4_busy_on_start : assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> stat_rdata[5]);
   a_r4_idle_on_stop : assert property (@(posedge clk) disable iff (!rst_n)
      stop_det && !start_det |=> !stat_rdata[5]);
   a_r2_done_sets : assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> stat_rdata[7] && stat_rdata[1]);
   a_r3_ctrl_clears : assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !addr_hit |=> !stat_rdata[6]);
   a_r10_w1c : assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && stat_wdata[4] && !arb_set |=> !stat_rdata[4]);
   a_r10_w0_hold : assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && !stat_wdata[4] && stat_rdata[4] |=> stat_rdata[4]);
   a_r11_arb_flags : assert property (@(posedge clk) disable iff (!rst_n)
      arb_set |=> stat_rdata[4] && stat_rdata[1]);
endmodule

bind i2c_stat_mon i2c_stat_mon_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stat_rdata(stat_rdata), .stat_wr(stat_wr),
   .stat_wdata(stat_wdata), .ctrl_wr(ctrl_wr), .arb_set(arb_set),
   .addr_hit(addr_hit), .byte_done(byte_done),
   .start_det(start_det), .stop_det(stop_det));

// File: tb/i2c_stat_mon_test.sv
module i2c_stat_mon_test;
   localparam int H = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
   logic [6:0] own_addr = '0;
   logic       master_mode = 0, tx_mode = 0, sda_drive_hi = 0;
   logic       start_req = 0, rstart_req = 0, stop_req = 0;
   logic       ctrl_wr = 0, stat_wr = 0, irq_en = 0;
   logic [7:0] stat_wdata = '0, stat_rdata;
   logic       irq;

   int n_chk = 0, n_fail = 0;
   logic exp_srw = 1'b0;

   i2c_stat_mon uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .own_addr(own_addr), .master_mode(master_mode), .tx_mode(tx_mode),
      .sda_drive_hi(sda_drive_hi), .start_req(start_req),
      .rstart_req(rstart_req), .stop_req(stop_req), .ctrl_wr(ctrl_wr),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(irq_en),
      .stat_rdata(stat_rdata), .irq(irq));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic v, input logic drv);
      sda_in = v; sda_drive_hi = drv; wait_cyc(H);
      scl_in = 1'b1; wait_cyc(H);
      scl_in = 1'b0; wait_cyc(H);
   endtask

   task automatic gen_start();
      sda_drive_hi = 0;
      sda_in = 1'b1; wait_cyc(H);
      scl_in = 1'b1; wait_cyc(H);
      sda_in = 1'b0; wait_cyc(H);
      scl_in = 1'b0; wait_cyc(H);
   endtask

   task automatic gen_stop();
      sda_drive_hi = 0;
      sda_in = 1'b0; wait_cyc(H);
      scl_in = 1'b1; wait_cyc(H);
      sda_in = 1'b1; wait_cyc(H);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic drv_match, input logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i], drv_match & b[i]);
      send_bit(ack, 1'b0);
   endtask

   task automatic pulse_stat_wr(input logic [7:0] d);
      stat_wdata = d; stat_wr = 1'b1; wait_cyc(1);
      stat_wr = 1'b0; stat_wdata = '0; wait_cyc(2);
   endtask

   task automatic pulse_ctrl();
      ctrl_wr = 1'b1; wait_cyc(1); ctrl_wr = 1'b0; wait_cyc(2);
   endtask

   task automatic pulse_start_req();
      start_req = 1'b1; wait_cyc(1); start_req = 1'b0; wait_cyc(2);
   endtask

   task automatic pulse_rstart_req();
      rstart_req = 1'b1; wait_cyc(1); rstart_req = 1'b0; wait_cyc(2);
   endtask

   function automatic logic hit_of(input logic [7:0] b, input logic [6:0] own, input logic mst);
      return !mst && (b[7:1] == own);
   endfunction

   // status after an address byte in slave mode (busy, no arbitration loss)
   function automatic logic [7:0] exp_after_addr(input logic [7:0] b, input logic ack,
                                                 input logic [6:0] own, input logic srw_prev);
      logic h;
      h = hit_of(b, own, 1'b0);
      return {1'b1, h, 1'b1, 1'b0, 1'b0, h ? b[0] : srw_prev, 1'b1, ack};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
   end

   initial begin
      logic [7:0] b, e;
      logic       ack;
      void'($urandom(32'd4711));
      wait_cyc(3);
      check("R1 reset status", stat_rdata, 8'h00);
      check("R1 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      wait_cyc(2);

      gen_start();
      check("R4 busy after START", stat_rdata & 8'hA0, 8'h20);

      for (int t = 0; t < 10; t++) begin
         own_addr = 7'($urandom);
         b = 8'($urandom);
         if (t % 2 == 0) b[7:1] = own_addr;
         if (t == 0) b[0] = 1'b1;
         ack = 1'($urandom);
         irq_en = 1'($urandom);
         pulse_stat_wr(8'h12);
         pulse_ctrl();
         if (t > 0) gen_start();
         for (int i = 7; i >= 5; i--) send_bit(b[i], 1'b0);
         check("R2 done flag low mid-byte", stat_rdata & 8'hE2, 8'h20);
         for (int i = 4; i >= 0; i--) send_bit(b[i], 1'b0);
         send_bit(ack, 1'b0);
         e = exp_after_addr(b, ack, own_addr, exp_srw);
         if (hit_of(b, own_addr, 1'b0)) exp_srw = b[0];
         check("R2 R3 R5 status after address byte", stat_rdata, e);
         check("R11 irq follows flag and enable", {7'd0, irq}, {7'd0, irq_en});
      end

      // last byte flags are set; writes of zeros and to other bits change nothing
      e = stat_rdata;
      pulse_stat_wr(8'h00);
      check("R10 write of zeros ignored", stat_rdata, e);
      pulse_stat_wr(8'hED);
      check("R10 other bits ignore writes", stat_rdata, e);
      pulse_stat_wr(8'h02);
      check("R10 W1C of interrupt flag", stat_rdata, e & 8'hFD);
      if (e[6]) begin
         pulse_ctrl();
         check("R3 ctrl_wr clears addressed", stat_rdata, e & 8'hBD);
      end
      gen_stop();
      check("R4 idle after STOP", stat_rdata & 8'h30, 8'h00);

      // R6: transmit bit mismatch as master
      master_mode = 1; tx_mode = 1;
      gen_start();
      send_bit(1'b1, 1'b1);
      send_bit(1'b0, 1'b0);
      check("R6 no loss while lines agree", stat_rdata & 8'h10, 8'h00);
      send_bit(1'b0, 1'b1);
      check("R6 loss on transmit mismatch", stat_rdata & 8'h12, 8'h12);
      pulse_stat_wr(8'h10);
      check("R10 W1C arbitration bit only", stat_rdata & 8'h12, 8'h02);
      pulse_stat_wr(8'h02);
      master_mode = 0;
      gen_stop();

      // R7: acknowledge of a received data byte
      master_mode = 1; tx_mode = 1;
      gen_start();
      send_byte(8'hA4, 1'b1, 1'b0);
      check("R7 no loss on address byte", stat_rdata & 8'h10, 8'h00);
      pulse_stat_wr(8'h12);
      tx_mode = 0;
      for (int i = 0; i < 8; i++) send_bit(1'($urandom), 1'b0);
      check("R7 no loss on received bits", stat_rdata & 8'h10, 8'h00);
      send_bit(1'b0, 1'b1);
      check("R7 loss on acknowledge bit", stat_rdata & 8'h10, 8'h10);
      pulse_stat_wr(8'h12);
      master_mode = 0;
      gen_stop();

      // R8: start while busy, repeated start as slave
      pulse_start_req();
      check("R8 start request while idle", stat_rdata & 8'h10, 8'h00);
      gen_start();
      pulse_start_req();
      check("R8 start request while busy", stat_rdata & 8'h12, 8'h12);
      pulse_stat_wr(8'h12);
      master_mode = 1;
      pulse_rstart_req();
      check("R8 repeated start as master", stat_rdata & 8'h10, 8'h00);
      master_mode = 0;
      pulse_rstart_req();
      check("R8 repeated start as slave", stat_rdata & 8'h10, 8'h10);
      pulse_stat_wr(8'h12);

      // R9: stop not requested by master
      master_mode = 1; stop_req = 1;
      gen_stop();
      check("R9 requested stop", stat_rdata & 8'h30, 8'h00);
      gen_start();
      stop_req = 0;
      gen_stop();
      check("R9 unrequested stop", stat_rdata & 8'h32, 8'h12);
      check("R11 irq with enable", {7'd0, irq}, {7'd0, irq_en});
      master_mode = 0;

      report();
      $finish;
   end
endmodule